// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block is the control register and address/data holding stage that sits between a processor bus and a nonvolatile memory array. Software arms a capture, performs one ordinary store to the array, and then turns on the high-voltage pump to program or erase the captured location. The block grabs the target address and data of that store, then ignores all other array stores for as long as capture stays armed.

Three control bits make up the register: a capture arm, an erase/program mode select and a pump enable. The pump enable is guarded. It cannot be turned on until a capture has been taken. While it is on, the arm bit and the mode bit cannot be changed. Turning the pump off is always accepted. All checks in a given write use the register contents as they stood before that write.

Top module: `flash_pe_ctl`

## Requirements
- R1: A bus write to address CTRL_ADDR (default 0x10) loads the control register from the write data. Bit 0 is capture arm, bit 1 is erase mode (1 = erase, 0 = program) and bit 2 is pump enable. Other data bits are ignored. When the pump was off before the write, the arm and mode bits take the written values.
- R2: When arm is set and no capture has been taken, a bus write to an array address in [ARR_BASE, ARR_LAST] (default 0x40..0xBF) stores that address and data in the holding latches. The captured flag is 1 in the cycle after the write.
- R3: After a capture, further array writes leave the holding latches unchanged for as long as arm stays set. Control writes still take effect.
- R4: A write that sets pump enable is ignored, and the pump stays off, unless a capture existed before the write and the same write keeps arm at 1. A single write that sets arm and pump together therefore leaves the pump off.
- R5: While the pump is on, a write that clears arm is ignored and arm stays 1.
- R6: While the pump is on, a write that changes the mode bit is ignored and the mode bit keeps its value.
- R7: Clearing the pump is always accepted. In that same write, arm and mode are still judged against the old pump value. A later write may then change them.
- R8: A write to an address outside the array range never causes a capture. An array write while arm is clear causes no capture either.
- R9: The captured flag clears when arm is cleared. Re-arming then allows a new capture.
- R10: A capture is taken for any valid array address in either mode.
- R11: On a clock edge with rst_n low, all control bits, the captured flag and the holding latches become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | AW | Bus write address |
| bus_wdata | input | DW | Bus write data |
| arm_o | output | 1 | Capture arm bit |
| erase_o | output | 1 | Mode bit, 1 = erase |
| pump_en_o | output | 1 | High-voltage pump enable |
| cap_valid_o | output | 1 | A capture has been taken since arming |
| cap_addr_o | output | AW | Captured array address |
| cap_data_o | output | DW | Captured write data |

## Verification
The bench sweeps every control write value from every reachable register state: arm and mode with no capture, and mode and pump after a capture. This catches a pump that turns on without captured data, or that turns on while the same write drops arm. It also catches arm or mode bits that slip while the pump is on, and interlock checks that read the new value instead of the old one. Every bus address is swept as a capture target, which exposes off-by-one range bounds and captures from control or out-of-range writes. Further runs show that a second array write overwrites nothing, that disarming clears the captured flag, and that a new capture works after re-arming.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    // Control bit positions inside the control register write data.
    localparam int BIT_ARM   = 0;
    localparam int BIT_ERASE = 1;
    localparam int BIT_PUMP  = 2;
    localparam int CTL_BITS  = 3;

    typedef struct packed {
        logic arm;
        logic erase;
        logic pump;
        logic valid;
    } pe_ctl_t;

    localparam pe_ctl_t CTL_RESET = '{arm: 1'b0, erase: 1'b0, pump: 1'b0, valid: 1'b0};

endpackage

// File: rtl/flash_pe_addr_dec.sv
module flash_pe_addr_dec #(
    parameter int          AW        = 8,
    parameter logic [AW-1:0] ARR_BASE  = 8'h40,
    parameter logic [AW-1:0] ARR_LAST  = 8'hBF,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h10
) (
    input  logic [AW-1:0] addr,
    output logic          hit_arr,
    output logic          hit_ctl
);

    logic above_base;

    // A zero base needs no lower compare; pick the variant at elaboration.
    generate
        if (ARR_BASE == '0) begin : g_base_zero
            assign above_base = 1'b1;
        end else begin : g_base_cmp
            assign above_base = (addr >= ARR_BASE);
        end
    endgenerate

    assign hit_arr = above_base && (addr <= ARR_LAST);
    assign hit_ctl = (addr == CTRL_ADDR);

endmodule

// File: rtl/flash_pe_ctl_next.sv
module flash_pe_ctl_next
    import flash_pe_pkg::*;
(
    input  pe_ctl_t                cur,
    input  logic                   ctl_wr,
    input  logic [CTL_BITS-1:0]    wbits,
    input  logic                   capture,
    output pe_ctl_t                nxt
);

    logic arm_new;

    always_comb begin
        nxt     = cur;
        arm_new = cur.arm;

        if (ctl_wr) begin
            // Arm and mode are frozen while the pump was on before this write.
            if (!cur.pump) begin
                arm_new   = wbits[BIT_ARM];
                nxt.erase = wbits[BIT_ERASE];
            end
            nxt.arm = arm_new;

            // The pump may always be dropped; raising it needs a prior
            // capture and an arm bit that survives this write.
            if (!wbits[BIT_PUMP]) begin
                nxt.pump = 1'b0;
            end else if (cur.valid && arm_new) begin
                nxt.pump = 1'b1;
            end

            if (!arm_new) begin
                nxt.valid = 1'b0;
            end
        end else if (capture) begin
            nxt.valid = 1'b1;
        end
    end

endmodule

// File: rtl/flash_pe_hold.sv
module flash_pe_hold #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          capture,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] addr_cur,
    input  logic [DW-1:0] data_cur,
    output logic [AW-1:0] addr_nxt,
    output logic [DW-1:0] data_nxt
);

    always_comb begin
        addr_nxt = addr_cur;
        data_nxt = data_cur;
        if (capture) begin
            addr_nxt = wr_addr;
            data_nxt = wr_data;
        end
    end

endmodule

// File: rtl/flash_pe_ctl.sv
module flash_pe_ctl
    import flash_pe_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] ARR_BASE  = 8'h40,
    parameter logic [AW-1:0] ARR_LAST  = 8'hBF,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          arm_o,
    output logic          erase_o,
    output logic          pump_en_o,
    output logic          cap_valid_o,
    output logic [AW-1:0] cap_addr_o,
    output logic [DW-1:0] cap_data_o
);

    localparam int WB = (DW < CTL_BITS) ? DW : CTL_BITS;

    typedef struct packed {
        pe_ctl_t       ctl;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } pe_state_t;

    pe_state_t state_d, state_q;

    logic                hit_arr, hit_ctl;
    logic                ctl_wr, capture;
    logic [CTL_BITS-1:0] wbits;
    pe_ctl_t             ctl_nxt;
    logic [AW-1:0]       addr_nxt;
    logic [DW-1:0]       data_nxt;

    flash_pe_addr_dec #(
        .AW(AW), .ARR_BASE(ARR_BASE), .ARR_LAST(ARR_LAST), .CTRL_ADDR(CTRL_ADDR)
    ) dec_i (
        .addr    (bus_addr),
        .hit_arr (hit_arr),
        .hit_ctl (hit_ctl)
    );

    always_comb begin
        wbits          = '0;
        wbits[WB-1:0]  = bus_wdata[WB-1:0];
        ctl_wr         = bus_wr && hit_ctl;
        capture        = bus_wr && hit_arr && state_q.ctl.arm && !state_q.ctl.valid;
    end

    flash_pe_ctl_next ctl_i (
        .cur     (state_q.ctl),
        .ctl_wr  (ctl_wr),
        .wbits   (wbits),
        .capture (capture),
        .nxt     (ctl_nxt)
    );

    flash_pe_hold #(.AW(AW), .DW(DW)) hold_i (
        .capture  (capture),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .addr_cur (state_q.addr),
        .data_cur (state_q.data),
        .addr_nxt (addr_nxt),
        .data_nxt (data_nxt)
    );

    always_comb begin
        state_d.ctl  = ctl_nxt;
        state_d.addr = addr_nxt;
        state_d.data = data_nxt;
        if (!rst_n) begin
            state_d.ctl  = CTL_RESET;
            state_d.addr = '0;
            state_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign arm_o       = state_q.ctl.arm;
    assign erase_o     = state_q.ctl.erase;
    assign pump_en_o   = state_q.ctl.pump;
    assign cap_valid_o = state_q.ctl.valid;
    assign cap_addr_o  = state_q.addr;
    assign cap_data_o  = state_q.data;

endmodule

// File: rtl/flash_pe_ctl_chk.sv
module flash_pe_ctl_chk #(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] ARR_BASE  = 8'h40,
    parameter logic [AW-1:0] ARR_LAST  = 8'hBF,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          arm_o,
    input logic          erase_o,
    input logic          pump_en_o,
    input logic          cap_valid_o,
    input logic [AW-1:0] cap_addr_o,
    input logic [DW-1:0] cap_data_o
);

    logic in_arr, is_ctl;
    assign in_arr = (bus_addr >= ARR_BASE) && (bus_addr <= ARR_LAST);
    assign is_ctl = (bus_addr == CTRL_ADDR);

    // R4: the pump is never on without a capture and arm.
    p_pump_needs_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pump_en_o |-> (cap_valid_o && arm_o));

    // R5: disarm attempt while pumping is ignored.
    p_arm_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_en_o && bus_wr && is_ctl && !bus_wdata[0]) |=> arm_o);

    // R6: mode bit stable while pumping.
    p_mode_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pump_en_o |=> $stable(erase_o));

    // R2: capture of an armed array write.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_o && !cap_valid_o && bus_wr && in_arr) |=>
        (cap_valid_o && cap_addr_o == $past(bus_addr) && cap_data_o == $past(bus_wdata)));

    // R3: latches hold once captured.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_o |=> ($stable(cap_addr_o) && $stable(cap_data_o)));

    // R8: no capture from out-of-range or unarmed writes.
    p_no_stray_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid_o && !(bus_wr && in_arr && arm_o)) |=> !cap_valid_o);

    // R9: captured flag falls only with arm cleared.
    p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_o && !arm_o) |-> 1'b0);

endmodule

bind flash_pe_ctl flash_pe_ctl_chk #(
    .AW(AW), .DW(DW), .ARR_BASE(ARR_BASE), .ARR_LAST(ARR_LAST), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .arm_o       (arm_o),
    .erase_o     (erase_o),
    .pump_en_o   (pump_en_o),
    .cap_valid_o (cap_valid_o),
    .cap_addr_o  (cap_addr_o),
    .cap_data_o  (cap_data_o)
);

// File: tb/flash_pe_ctl_tb_top.sv
module flash_pe_ctl_tb_top;

    localparam int         AW    = 8;
    localparam int         DW    = 8;
    localparam logic [7:0] BASE  = 8'h40;
    localparam logic [7:0] LAST  = 8'hBF;
    localparam logic [7:0] CTRL  = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          arm_o, erase_o, pump_en_o, cap_valid_o;
    logic [AW-1:0] cap_addr_o;
    logic [DW-1:0] cap_data_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2ns clk = ~clk;

    flash_pe_ctl #(.AW(AW), .DW(DW), .ARR_BASE(BASE), .ARR_LAST(LAST), .CTRL_ADDR(CTRL)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .arm_o(arm_o), .erase_o(erase_o), .pump_en_o(pump_en_o), .cap_valid_o(cap_valid_o),
        .cap_addr_o(cap_addr_o), .cap_data_o(cap_data_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #400us;
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        do_reset();
        // R11: reset state
        check({arm_o, erase_o, pump_en_o, cap_valid_o} == 4'b0, "R11 ctl reset",
              int'({arm_o, erase_o, pump_en_o, cap_valid_o}), 0);
        check(cap_addr_o == 0 && cap_data_o == 0, "R11 latch reset", int'(cap_addr_o), 0);

        // Control sweep over reachable states and all 8 written values (R1 R4 R5 R6 R7)
        for (int st = 0; st < 8; st++) begin
            for (int w = 0; w < 8; w++) begin
                logic v0, a0, e0, p0;
                logic ea, ee, ep, ev;
                v0 = st[2];
                e0 = st[0];
                a0 = v0 ? 1'b1 : st[1];
                p0 = v0 ? st[1] : 1'b0;
                do_reset();
                bus_write(CTRL, {6'b0, e0, a0});
                if (v0) bus_write(BASE + 8'h3, 8'h5A);
                if (p0) bus_write(CTRL, {5'b0, 1'b1, e0, 1'b1});
                bus_write(CTRL, 8'hF8 | 8'(w));
                ea = p0 ? 1'b1 : w[0];
                ee = p0 ? e0 : w[1];
                ep = w[2] & v0 & ea;
                ev = v0 & ea;
                check(arm_o == ea, p0 ? "R5 arm" : "R1 arm", int'(arm_o), int'(ea));
                check(erase_o == ee, p0 ? "R6 mode" : "R1 mode", int'(erase_o), int'(ee));
                check(pump_en_o == ep, p0 ? "R7 pump" : "R4 pump", int'(pump_en_o), int'(ep));
                check(cap_valid_o == ev, "R9 valid after ctl write", int'(cap_valid_o), int'(ev));
                if (p0 && !w[2]) begin
                    // R7: after pump drop, arm and mode become writable
                    bus_write(CTRL, {6'b0, ~e0, 1'b0});
                    check(arm_o == 1'b0 && erase_o == ~e0, "R7 rewrite",
                          int'({arm_o, erase_o}), int'({1'b0, ~e0}));
                end
            end
        end

        // Address sweep: capture range, in both modes (R2 R8 R10)
        for (int a = 0; a < 256; a++) begin
            logic inr;
            inr = (a >= int'(BASE)) && (a <= int'(LAST));
            do_reset();
            bus_write(CTRL, {6'b0, a[0], 1'b1});
            bus_write(8'(a), 8'(a ^ 8'hA5));
            if (8'(a) == CTRL) continue;
            check(cap_valid_o == inr, inr ? "R2 capture flag" : "R8 out of range",
                  int'(cap_valid_o), int'(inr));
            if (inr) begin
                check(cap_addr_o == 8'(a) && cap_data_o == 8'(a ^ 8'hA5), "R10 captured value",
                      int'({cap_addr_o, cap_data_o}), int'({8'(a), 8'(a ^ 8'hA5)}));
                // R3: second array write blocked
                bus_write(LAST - 8'(a - int'(BASE)), 8'h3C);
                check(cap_addr_o == 8'(a) && cap_data_o == 8'(a ^ 8'hA5), "R3 blocked",
                      int'({cap_addr_o, cap_data_o}), int'({8'(a), 8'(a ^ 8'hA5)}));
            end
        end

        // R8: unarmed array write does not capture
        do_reset();
        bus_write(BASE, 8'h11);
        check(cap_valid_o == 1'b0, "R8 unarmed", int'(cap_valid_o), 0);

        // R9: disarm clears flag, re-arm allows a new capture
        do_reset();
        bus_write(CTRL, 8'h01);
        bus_write(BASE + 8'h1, 8'h22);
        bus_write(CTRL, 8'h00);
        check(cap_valid_o == 1'b0, "R9 disarm clears", int'(cap_valid_o), 0);
        bus_write(CTRL, 8'h01);
        bus_write(BASE + 8'h7, 8'h77);
        check(cap_valid_o && cap_addr_o == BASE + 8'h7 && cap_data_o == 8'h77, "R9 recapture",
              int'({cap_addr_o, cap_data_o}), int'({BASE + 8'h7, 8'h77}));

        // R4: arm and pump in one write leaves pump off
        do_reset();
        bus_write(CTRL, 8'h05);
        check(pump_en_o == 1'b0 && arm_o == 1'b1, "R4 same write", int'(pump_en_o), 0);

        // R11: reset mid-operation clears everything
        bus_write(BASE, 8'h99);
        bus_write(CTRL, 8'h07);
        do_reset();
        check({arm_o, erase_o, pump_en_o, cap_valid_o, cap_addr_o, cap_data_o} == '0,
              "R11 reset after use", int'(pump_en_o), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule